// File: doc/BRIEF.md
# Nonrestoring Fractional Divide Step

This block performs one step of a nonrestoring fractional division on a 56-bit accumulator. The accumulator holds both the running remainder and the quotient. It is split into an 8-bit guard extension, a 24-bit upper word and a 24-bit lower word. The divisor is a 24-bit signed fraction.

On each step the block does the following:
- It decides whether to add or subtract the divisor by comparing the accumulator sign with the divisor sign.
- It shifts the accumulator left by one, and the stored quotient bit enters at bit 0.
- It applies the sign-extended divisor to the upper 32 bits.
- It keeps the inverse of the new sign as the next quotient bit.

The caller first loads the dividend, the divisor and an initial carry. It then pulses the step strobe N times (1 to 24) to collect an N-bit quotient in the lower word. Operand sign handling, the iteration count and the correction of the remainder afterwards are left to the caller. Results are meaningful only while the magnitude of the dividend is below the magnitude of the divisor.

Top module: `fdiv_step`

## Requirements
- R1: A synchronous active-high reset clears the accumulator, the divisor, the carry, the overflow flag and the sticky limit flag to zero on the next clock edge.
- R2: When `load` is high on a clock edge, the accumulator, the divisor and the carry take `load_acc`, `load_div` and `load_carry`, and the overflow flag clears. This holds even when `step` is also high, so load takes priority and no step is done in that cycle.
- R3: In a cycle with neither `load` nor `step` high, the accumulator, carry, overflow and limit outputs keep their values.
- R4: On a step, the lower 24 bits become `{old[22:0], old_carry}`: a left shift by one with the previous carry entering bit 0.
- R5: On a step, the upper 32 bits become the upper 32 bits of the shifted accumulator, plus the 8-bit sign-extended divisor when old bit 55 XOR divisor bit 23 equals 1. When that XOR equals 0, the sign-extended divisor is subtracted instead. The result is taken modulo 2^32.
- R6: After a step, the carry output equals the inverse of bit 55 of the new accumulator.
- R7: On a step, the overflow flag is set to old bit 55 XOR old bit 54, which is true when the left shift changes the accumulator's most significant bit.
- R8: The limit flag becomes 1 on any step that sets overflow. Once set, only reset clears it; neither loads nor later steps clear it.
- R9: Take accumulator 0x00_0E66D7_F2832C, divisor 0x123456 and carry 0. After 24 steps the lower word reads 0x654321. The upper 32 bits plus the sign-extended divisor then give 0x00000100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Write initial accumulator, divisor and carry |
| load_acc | input | 56 | Initial accumulator value |
| load_div | input | 24 | Signed fractional divisor |
| load_carry | input | 1 | Initial carry (first quotient bit shifted in) |
| step | input | 1 | Run one division iteration |
| acc_o | output | 56 | Accumulator: remainder above, quotient below |
| carry_o | output | 1 | Next quotient bit |
| ovf_o | output | 1 | Shift changed the accumulator MSB on the last step |
| limit_o | output | 1 | Sticky overflow |

## Verification
The overflow and limit flags are the hardest part to reach. With legal operands, the remainder never gets large enough for the shift to flip bit 55, so no ordinary division raises them. The stimulus therefore loads an accumulator whose bits 55 and 54 differ, steps once, and confirms that both flags rise. It then loads a legal operand, steps again, and confirms that overflow drops while the limit flag persists until reset.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  localparam int EXT_W = 8;
  localparam int HI_W  = 24;
  localparam int LO_W  = 24;

  typedef enum logic {
    OP_SUB = 1'b0,
    OP_ADD = 1'b1
  } fdiv_op_e;
endpackage

// File: rtl/fdiv_op_sel.sv
module fdiv_op_sel
  import fdiv_pkg::*;
(
  input  logic     rem_sign,
  input  logic     div_sign,
  output fdiv_op_e op
);
  // Differing signs move the remainder toward zero by adding.
  always_comb begin
    if (rem_sign ^ div_sign) op = OP_ADD;
    else                     op = OP_SUB;
  end
endmodule

// File: rtl/fdiv_datapath.sv
module fdiv_datapath
  import fdiv_pkg::*;
#(
  parameter int GUARD_W = EXT_W,
  parameter int UPPER_W = HI_W,
  parameter int LOWER_W = LO_W,
  localparam int TOP_W  = GUARD_W + UPPER_W,
  localparam int TOT_W  = TOP_W + LOWER_W
) (
  input  logic [TOT_W-1:0]   acc_in,
  input  logic               cin,
  input  logic [UPPER_W-1:0] divisor,
  input  fdiv_op_e           op,
  output logic [TOT_W-1:0]   acc_out,
  output logic               cout
);
  logic [TOT_W-1:0] shifted;
  logic [TOP_W-1:0] dv_ext;
  logic [TOP_W-1:0] top_res;

  assign shifted = {acc_in[TOT_W-2:0], cin};

  generate
    if (GUARD_W > 0) begin : g_ext
      assign dv_ext = {{GUARD_W{divisor[UPPER_W-1]}}, divisor};
    end else begin : g_noext
      assign dv_ext = divisor;
    end
  endgenerate

  always_comb begin
    if (op == OP_ADD) top_res = shifted[TOT_W-1:LOWER_W] + dv_ext;
    else              top_res = shifted[TOT_W-1:LOWER_W] - dv_ext;
  end

  assign acc_out = {top_res, shifted[LOWER_W-1:0]};
  assign cout    = ~top_res[TOP_W-1];
endmodule

// File: rtl/fdiv_flag_gen.sv
module fdiv_flag_gen #(
  parameter int TOT_W = 56
) (
  input  logic [TOT_W-1:0] acc_in,
  output logic             msb_flip
);
  // After a one-bit left shift the new MSB is the old bit below it.
  assign msb_flip = acc_in[TOT_W-1] ^ acc_in[TOT_W-2];
endmodule

// File: rtl/fdiv_step.sv
module fdiv_step
  import fdiv_pkg::*;
#(
  parameter int GUARD_W = EXT_W,
  parameter int UPPER_W = HI_W,
  parameter int LOWER_W = LO_W,
  localparam int TOT_W  = GUARD_W + UPPER_W + LOWER_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [TOT_W-1:0]   load_acc,
  input  logic [UPPER_W-1:0] load_div,
  input  logic               load_carry,
  input  logic               step,
  output logic [TOT_W-1:0]   acc_o,
  output logic               carry_o,
  output logic               ovf_o,
  output logic               limit_o
);
  logic [TOT_W-1:0]   acc_q;
  logic [UPPER_W-1:0] div_q;
  logic               carry_q;
  logic               ovf_q;
  logic               lim_q;

  fdiv_op_e           op;
  logic [TOT_W-1:0]   acc_nx;
  logic               carry_nx;
  logic               flip;

  fdiv_op_sel u_sel (
    .rem_sign (acc_q[TOT_W-1]),
    .div_sign (div_q[UPPER_W-1]),
    .op       (op)
  );

  fdiv_datapath #(
    .GUARD_W (GUARD_W),
    .UPPER_W (UPPER_W),
    .LOWER_W (LOWER_W)
  ) u_dp (
    .acc_in  (acc_q),
    .cin     (carry_q),
    .divisor (div_q),
    .op      (op),
    .acc_out (acc_nx),
    .cout    (carry_nx)
  );

  fdiv_flag_gen #(.TOT_W(TOT_W)) u_flag (
    .acc_in   (acc_q),
    .msb_flip (flip)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      div_q   <= '0;
      carry_q <= 1'b0;
      ovf_q   <= 1'b0;
      lim_q   <= 1'b0;
    end else if (load) begin
      acc_q   <= load_acc;
      div_q   <= load_div;
      carry_q <= load_carry;
      ovf_q   <= 1'b0;
    end else if (step) begin
      acc_q   <= acc_nx;
      carry_q <= carry_nx;
      ovf_q   <= flip;
      lim_q   <= lim_q | flip;
    end
  end

  assign acc_o   = acc_q;
  assign carry_o = carry_q;
  assign ovf_o   = ovf_q;
  assign limit_o = lim_q;

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (!load && !step) |=> ($stable(acc_o) && $stable(carry_o) && $stable(ovf_o) && $stable(limit_o)));

  a_r4_shift_in: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> (acc_o[0] == $past(carry_o)) && (acc_o[LOWER_W-1:1] == $past(acc_o[LOWER_W-2:0])));

  a_r6_carry_sign: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> (carry_o != acc_o[TOT_W-1]));

  a_r7_ovf: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> (ovf_o == ($past(acc_o[TOT_W-1]) ^ $past(acc_o[TOT_W-2]))));

  a_r2_load_wins: assert property (@(posedge clk) disable iff (rst)
    load |=> (acc_o == $past(load_acc)) && (carry_o == $past(load_carry)) && !ovf_o);

  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    limit_o |=> limit_o);

  a_r8_ovf_implies_limit: assert property (@(posedge clk) disable iff (rst)
    ovf_o |-> limit_o);
endmodule

// File: tb/fdiv_step_tb.sv
module fdiv_step_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load = 1'b0;
  logic [55:0] load_acc = '0;
  logic [23:0] load_div = '0;
  logic        load_carry = 1'b0;
  logic        step = 1'b0;
  logic [55:0] acc_o;
  logic        carry_o, ovf_o, limit_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [55:0] acc;
    logic        c;
    logic        v;
    logic        l;
    string       tag;
  } exp_t;
  exp_t q[$];

  logic [55:0] m_acc;
  logic [23:0] m_div;
  logic        m_c, m_v, m_l;

  always #5 clk = ~clk;

  fdiv_step u_dut (
    .clk(clk), .rst(rst), .load(load), .load_acc(load_acc), .load_div(load_div),
    .load_carry(load_carry), .step(step), .acc_o(acc_o), .carry_o(carry_o),
    .ovf_o(ovf_o), .limit_o(limit_o)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference step computed from R4..R8
  task automatic model_step();
    logic [55:0] sh;
    logic [31:0] up, sx;
    sh = {m_acc[54:0], m_c};
    sx = {{8{m_div[23]}}, m_div};
    up = (m_acc[55] ^ m_div[23]) ? sh[55:24] + sx : sh[55:24] - sx;
    m_v = m_acc[55] ^ m_acc[54];
    m_l = m_l | m_v;
    m_acc = {up, sh[23:0]};
    m_c = ~m_acc[55];
  endtask

  task automatic cyc(input bit r, input bit ld, input logic [55:0] la, input logic [23:0] ldv,
                     input bit lc, input bit st, input string tag);
    exp_t e;
    @(negedge clk);
    rst = r; load = ld; load_acc = la; load_div = ldv; load_carry = lc; step = st;
    if (r) begin
      m_acc = '0; m_div = '0; m_c = 0; m_v = 0; m_l = 0;
    end else if (ld) begin
      m_acc = la; m_div = ldv; m_c = lc; m_v = 0;
    end else if (st) begin
      model_step();
    end
    e.acc = m_acc; e.c = m_c; e.v = m_v; e.l = m_l; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic drain();
    @(negedge clk);
    rst = 0; load = 0; step = 0;
    while (q.size() != 0) @(negedge clk);
  endtask

  // Monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() != 0) begin
        exp_t e;
        e = q.pop_front();
        check(acc_o == e.acc, {e.tag, " acc"}, {8'h0, acc_o}, {8'h0, e.acc});
        check(carry_o == e.c, {e.tag, " carry"}, {63'h0, carry_o}, {63'h0, e.c});
        check(ovf_o == e.v, {e.tag, " ovf"}, {63'h0, ovf_o}, {63'h0, e.v});
        check(limit_o == e.l, {e.tag, " limit"}, {63'h0, limit_o}, {63'h0, e.l});
      end
    end
  end

  // Watchdog
  initial begin
    #2000000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rem;
    m_acc = '0; m_div = '0; m_c = 0; m_v = 0; m_l = 0;
    // R1 reset state
    cyc(1, 0, '0, '0, 0, 0, "R1 reset");
    cyc(1, 0, '0, '0, 0, 0, "R1 reset");
    // R2 load, R9 vector with R4 R5 R6 stepping
    cyc(0, 1, 56'h00_0E66D7_F2832C, 24'h123456, 0, 0, "R2 load");
    for (int i = 0; i < 24; i++) cyc(0, 0, '0, '0, 0, 1, "R5 R6 step");
    drain();
    check(acc_o[23:0] == 24'h654321, "R9 quotient", {40'h0, acc_o[23:0]}, 64'h654321);
    rem = acc_o[55:24] + 32'h00123456;
    check(rem == 32'h00000100, "R9 remainder", {32'h0, rem}, 64'h100);
    // R3 idle hold
    for (int i = 0; i < 3; i++) cyc(0, 0, 56'hFF_FFFFFF_FFFFFF, 24'hFFFFFF, 1, 0, "R3 idle");
    // R2 load has priority over step
    cyc(0, 1, 56'h00_200000_000000, 24'h400000, 1, 1, "R2 load+step");
    // R4 carry 1 shifting in, R5 subtract with same signs
    for (int i = 0; i < 6; i++) cyc(0, 0, '0, '0, 0, 1, "R4 R5 pos div");
    // R5 add path: negative divisor with positive remainder
    cyc(0, 1, 56'h00_100000_ABCDEF, 24'hC00000, 0, 0, "R2 load neg div");
    for (int i = 0; i < 8; i++) cyc(0, 0, '0, '0, 0, 1, "R5 R6 neg div");
    // R7 R8 overflow: bits 55 and 54 differ
    cyc(0, 1, 56'h40_000000_000000, 24'h100000, 0, 0, "R2 load ovf");
    cyc(0, 0, '0, '0, 0, 1, "R7 R8 ovf set");
    cyc(0, 1, 56'h00_010000_000000, 24'h200000, 0, 0, "R8 load keeps limit");
    cyc(0, 0, '0, '0, 0, 1, "R7 R8 ovf clear limit held");
    cyc(0, 0, '0, '0, 0, 1, "R8 limit held");
    // R1 reset clears the sticky flag
    cyc(1, 0, '0, '0, 0, 0, "R1 reset clears limit");
    drain();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule